// File: doc/BRIEF.md
# Flash Status and Write-Protection Unit

This block keeps the two status bytes of a serial flash device and decides whether the device may accept a write. The first byte holds a busy flag, the write-enable latch, a two-bit protection level, an auto-increment programming flag and a lock-down bit. The second byte holds two independent lock bits, one for the top 4 KB sector and one for the bottom 4 KB sector. A command decoder feeds the block one event strobe per finished command, together with the length and data bytes of a status write. The write-protect pin is also an input. The array controller drives the busy and auto-increment flags straight through.

The block returns both status bytes. It also checks an address span given by a base address and an erase or program granularity. It returns whether that span touches protected memory, whether a program or erase on that span may start, and whether a whole-array erase may start. Events are single-cycle strobes with no back-pressure: the block takes one event in every cycle that `ev_valid` is high, and it never stalls the decoder.

Top module: `flash_status_unit`

## Requirements
- R1: After reset, status byte 0 reads 0x0C and status byte 1 reads 0x00. In byte 0 the bits are 0 busy, 1 write-enable latch, 2–3 protection level, 6 auto-increment, 7 lock-down, with bits 4–5 always 0. In byte 1, bit 2 is the top-sector lock and bit 3 the bottom-sector lock, and every other bit is always 0.
- R2: Bit 0 of byte 0 equals `op_busy` and bit 6 equals `aai_mode` in the same cycle.
- R3: A status write (event code 4) takes effect only if the event just before it was write-enable (code 1) or status-arm (code 3). Idle cycles between the two events do not break this. Any other event in between cancels it. Code 0 means any other command, code 2 is write-disable, code 5 is program-done and code 6 is erase-done.
- R4: When `wp_n` is 0 and the lock-down bit is 1, a status write is ignored. When `wp_n` is 1, the lock-down bit has no effect and a status write proceeds.
- R5: An executed write with length 1 loads the lock-down bit, bit 3 and bit 2 of byte 0 from the same bits of `ev_d0`. With length 2 it also loads bits 3 and 2 of byte 1 from `ev_d1`. Any other length, or `op_busy` = 1, leaves both bytes unchanged.
- R6: The write-enable latch is set by event 1. It is cleared by events 2, 4, 5 and 6, and by a 1-to-0 fall of `aai_mode`. If event 1 arrives in the same cycle as that fall, the latch is set.
- R7: Protection level 00 protects nothing. Level 01 protects 0x30000–0x3FFFF, level 10 protects 0x20000–0x3FFFF and level 11 protects the whole array. `chk_protected` is 1 when the checked span overlaps the protected range.
- R8: The span is one byte (`chk_span` = 0), the 4 KB sector (1), the 32 KB block (2) or the 64 KB block (3) that contains `chk_addr`. The span is protected if it includes the top 4 KB sector while the top lock is set, or the bottom 4 KB sector while the bottom lock is set.
- R9: `write_ok` = latch & !busy & !`chk_protected`. `chip_erase_ok` = latch & !busy & level 00 & both sector locks clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Command event strobe |
| ev_kind | input | 3 | Event code (see R3) |
| ev_len | input | 2 | Data byte count of a status write |
| ev_d0 | input | 8 | First status write byte |
| ev_d1 | input | 8 | Second status write byte |
| wp_n | input | 1 | Write-protect pin, active low |
| op_busy | input | 1 | Array operation in progress |
| aai_mode | input | 1 | Auto-increment programming active |
| chk_addr | input | 18 | Address whose span is checked |
| chk_span | input | 2 | Span granularity code |
| sr0 | output | 8 | Status byte 0 |
| sr1 | output | 8 | Status byte 1 |
| chk_protected | output | 1 | Span overlaps protected memory |
| write_ok | output | 1 | Program or erase on the span may start |
| chip_erase_ok | output | 1 | Whole-array erase may start |

## Verification
The write-enable latch has two update sources that can act in the same cycle: a set from a write-enable event, and a clear from the fall of the auto-increment flag. The bench provokes this collision directly, and also reaches it through random toggling of `aai_mode` under random events. It judges the result by the rule that the set wins. A status write arriving in the same cycle as `op_busy` is the second overlap the bench covers; both bytes must stay unchanged.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  typedef enum logic [2:0] {
    EV_OTHER   = 3'd0,
    EV_WREN    = 3'd1,
    EV_WRDI    = 3'd2,
    EV_ARM     = 3'd3,
    EV_STWR    = 3'd4,
    EV_PGDONE  = 3'd5,
    EV_ERDONE  = 3'd6
  } fsu_ev_e;

  typedef enum logic [1:0] {
    SP_BYTE  = 2'd0,
    SP_SECT  = 2'd1,
    SP_BLK32 = 2'd2,
    SP_BLK64 = 2'd3
  } fsu_span_e;
endpackage

// File: rtl/fsu_arm_track.sv
module fsu_arm_track
  import fsu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ev_valid,
  input  fsu_ev_e ev_kind,
  output logic    armed
);
  // Only the event type of the previous command matters; idle cycles hold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b0;
    else if (ev_valid) armed <= (ev_kind == EV_WREN) || (ev_kind == EV_ARM);
  end
endmodule

// File: rtl/fsu_wel_ctl.sv
module fsu_wel_ctl
  import fsu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ev_valid,
  input  fsu_ev_e ev_kind,
  input  logic    aai_mode,
  output logic    wel
);
  logic aai_q;
  logic set_now, clr_now;

  always_comb begin
    set_now = ev_valid && (ev_kind == EV_WREN);
    clr_now = (aai_q && !aai_mode) ||
              (ev_valid && (ev_kind == EV_WRDI || ev_kind == EV_STWR ||
                            ev_kind == EV_PGDONE || ev_kind == EV_ERDONE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aai_q <= 1'b0;
      wel   <= 1'b0;
    end else begin
      aai_q <= aai_mode;
      if (set_now)      wel <= 1'b1;
      else if (clr_now) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/fsu_prot_regs.sv
module fsu_prot_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_exec,
  input  logic       wr_two,
  input  logic [7:0] d0,
  input  logic [7:0] d1,
  output logic [1:0] level,
  output logic       lockdown,
  output logic       top_lock,
  output logic       bot_lock
);
  logic unused_bits;
  assign unused_bits = ^{d0[6:4], d0[1:0], d1[7:4], d1[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level    <= 2'b11;
      lockdown <= 1'b0;
      top_lock <= 1'b0;
      bot_lock <= 1'b0;
    end else if (wr_exec) begin
      level    <= d0[3:2];
      lockdown <= d0[7];
      if (wr_two) begin
        top_lock <= d1[2];
        bot_lock <= d1[3];
      end
    end
  end
endmodule

// File: rtl/fsu_span_chk.sv
module fsu_span_chk
  import fsu_pkg::*;
#(
  parameter int AW    = 18,
  parameter int SEC_W = 12,
  parameter int B32_W = 15,
  parameter int B64_W = 16
) (
  input  logic [AW-1:0] addr,
  input  fsu_span_e     span,
  input  logic [1:0]    level,
  input  logic          top_lock,
  input  logic          bot_lock,
  output logic          hit
);
  localparam int N_SPAN = 4;
  logic [AW-1:0] mask_tab [N_SPAN];

  // Low-bit masks for each granularity, built from the widths.
  for (genvar g = 0; g < N_SPAN; g++) begin : g_mask
    localparam int LOW = (g == 0) ? 0 : (g == 1) ? SEC_W : (g == 2) ? B32_W : B64_W;
    for (genvar b = 0; b < AW; b++) begin : g_bit
      assign mask_tab[g][b] = (b < LOW);
    end
  end

  logic [AW-1:0] end_a, base_a;
  logic lvl_hit, top_hit, bot_hit;

  always_comb begin
    end_a  = addr | mask_tab[span];
    base_a = addr & ~mask_tab[span];
    unique case (level)
      2'b00:   lvl_hit = 1'b0;
      2'b01:   lvl_hit = &end_a[AW-1:AW-2];
      2'b10:   lvl_hit = end_a[AW-1];
      default: lvl_hit = 1'b1;
    endcase
    top_hit = top_lock && (&end_a[AW-1:SEC_W]);
    bot_hit = bot_lock && (base_a[AW-1:SEC_W] == '0);
    hit     = lvl_hit || top_hit || bot_hit;
  end
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsu_pkg::*;
#(
  parameter int AW    = 18,
  parameter int SEC_W = 12,
  parameter int B32_W = 15,
  parameter int B64_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [2:0]    ev_kind,
  input  logic [1:0]    ev_len,
  input  logic [7:0]    ev_d0,
  input  logic [7:0]    ev_d1,
  input  logic          wp_n,
  input  logic          op_busy,
  input  logic          aai_mode,
  input  logic [AW-1:0] chk_addr,
  input  logic [1:0]    chk_span,
  output logic [7:0]    sr0,
  output logic [7:0]    sr1,
  output logic          chk_protected,
  output logic          write_ok,
  output logic          chip_erase_ok
);
  fsu_ev_e    kind_e;
  logic       armed, wel, lockdown, top_lock, bot_lock, wr_exec;
  logic [1:0] level;

  assign kind_e = fsu_ev_e'(ev_kind);

  fsu_arm_track u_arm (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(kind_e), .armed(armed)
  );

  fsu_wel_ctl u_wel (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(kind_e),
    .aai_mode(aai_mode), .wel(wel)
  );

  // Status write gate: armed, legal length, not busy, not pin-locked.
  assign wr_exec = ev_valid && (kind_e == EV_STWR) && armed && !op_busy &&
                   (ev_len == 2'd1 || ev_len == 2'd2) && !(!wp_n && lockdown);

  fsu_prot_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_exec(wr_exec), .wr_two(ev_len == 2'd2),
    .d0(ev_d0), .d1(ev_d1), .level(level), .lockdown(lockdown),
    .top_lock(top_lock), .bot_lock(bot_lock)
  );

  fsu_span_chk #(.AW(AW), .SEC_W(SEC_W), .B32_W(B32_W), .B64_W(B64_W)) u_span (
    .addr(chk_addr), .span(fsu_span_e'(chk_span)), .level(level),
    .top_lock(top_lock), .bot_lock(bot_lock), .hit(chk_protected)
  );

  assign sr0           = {lockdown, aai_mode, 2'b00, level, wel, op_busy};
  assign sr1           = {4'b0000, bot_lock, top_lock, 2'b00};
  assign write_ok      = wel && !op_busy && !chk_protected;
  assign chip_erase_ok = wel && !op_busy && (level == 2'b00) && !top_lock && !bot_lock;
endmodule

// File: rtl/fsu_checker.sv
module fsu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_valid,
  input logic [2:0] ev_kind,
  input logic       wp_n,
  input logic [7:0] sr0,
  input logic [7:0] sr1,
  input logic       chk_protected,
  input logic       chip_erase_ok
);
  // R1: reset state seen on the first edge after reset was held
  p_reset_vals_r1: assert property (@(posedge clk)
    !rst_n |=> (sr0[7:1] == 7'b0000110 && sr1 == 8'h00));

  // R4: pin-locked status write leaves protection fields untouched
  p_pin_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == 3'd4 && !wp_n && sr0[7])
    |=> ($stable(sr0[7]) && $stable(sr0[3:2]) && $stable(sr1)));

  // R6: write-disable clears the latch
  p_wrdi_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == 3'd2) |=> !sr0[1]);

  // R7: full-array level protects every span
  p_full_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr0[3:2] == 2'b11) |-> chk_protected);

  // R9: whole-array erase permission implies its preconditions
  p_chip_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_ok |-> (sr0[1] && !sr0[0] && sr0[3:2] == 2'b00 && sr1[3:2] == 2'b00));
endmodule

bind flash_status_unit fsu_checker u_fsu_checker (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .wp_n(wp_n),
  .sr0(sr0), .sr1(sr1), .chk_protected(chk_protected), .chip_erase_ok(chip_erase_ok)
);

// File: tb/flash_status_unit_tb_top.sv
module flash_status_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int SEED  = 32'h1F5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [2:0] ev_kind = '0;
  logic [1:0] ev_len = '0;
  logic [7:0] ev_d0 = '0, ev_d1 = '0;
  logic wp_n = 1'b1, op_busy = 1'b0, aai_mode = 1'b0;
  logic [17:0] chk_addr = '0;
  logic [1:0] chk_span = '0;
  logic [7:0] sr0, sr1;
  logic chk_protected, write_ok, chip_erase_ok;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model state
  logic [1:0] m_lvl = 2'b11;
  logic m_bpl = 0, m_tsp = 0, m_bsp = 0, m_wel = 0, m_armed = 0, m_aai_q = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_len(ev_len),
    .ev_d0(ev_d0), .ev_d1(ev_d1), .wp_n(wp_n), .op_busy(op_busy), .aai_mode(aai_mode),
    .chk_addr(chk_addr), .chk_span(chk_span), .sr0(sr0), .sr1(sr1),
    .chk_protected(chk_protected), .write_ok(write_ok), .chip_erase_ok(chip_erase_ok)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_prot(input logic [17:0] a, input logic [1:0] sp);
    int sz, lo, hi, base;
    sz   = (sp == 0) ? 1 : (sp == 1) ? 4096 : (sp == 2) ? 32768 : 65536;
    base = (int'(a) / sz) * sz;
    hi   = base + sz - 1;
    lo   = base;
    exp_prot = 0;
    if (m_lvl == 2'b11) exp_prot = 1;
    if (m_lvl == 2'b10 && hi >= 'h20000) exp_prot = 1;
    if (m_lvl == 2'b01 && hi >= 'h30000) exp_prot = 1;
    if (m_tsp && hi >= 'h3F000) exp_prot = 1;
    if (m_bsp && lo < 'h1000) exp_prot = 1;
  endfunction

  task automatic compare_all();
    logic p;
    p = exp_prot(chk_addr, chk_span);
    check("R1 R2 R5 R6 status0", {24'd0, sr0}, {24'd0, m_bpl, aai_mode, 2'b00, m_lvl, m_wel, op_busy});
    check("R1 R5 status1", {24'd0, sr1}, {28'd0, m_bsp, m_tsp, 2'b00});
    check("R7 R8 protected", {31'd0, chk_protected}, {31'd0, p});
    check("R9 write_ok", {31'd0, write_ok}, {31'd0, m_wel & !op_busy & !p});
    check("R9 chip_erase_ok", {31'd0, chip_erase_ok},
          {31'd0, m_wel & !op_busy & (m_lvl == 2'b00) & !m_tsp & !m_bsp});
  endtask

  // Inputs are set at a negedge; advance one edge, update model, compare.
  task automatic step();
    logic ex, n_wel;
    ex = ev_valid && ev_kind == 3'd4 && m_armed && !op_busy &&
         (ev_len == 2'd1 || ev_len == 2'd2) && !(!wp_n && m_bpl);
    n_wel = m_wel;
    if (ev_valid && ev_kind == 3'd1) n_wel = 1;
    else if ((m_aai_q && !aai_mode) ||
             (ev_valid && (ev_kind == 3'd2 || ev_kind == 3'd4 || ev_kind == 3'd5 || ev_kind == 3'd6)))
      n_wel = 0;
    @(posedge clk); #1;
    m_wel = n_wel;
    if (ev_valid) m_armed = (ev_kind == 3'd1 || ev_kind == 3'd3);
    if (ex) begin
      m_lvl = ev_d0[3:2]; m_bpl = ev_d0[7];
      if (ev_len == 2'd2) begin m_tsp = ev_d1[2]; m_bsp = ev_d1[3]; end
    end
    m_aai_q = aai_mode;
    compare_all();
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic ev(input logic [2:0] k, input logic [1:0] l, input logic [7:0] a, input logic [7:0] b);
    ev_valid = 1; ev_kind = k; ev_len = l; ev_d0 = a; ev_d1 = b;
    step();
  endtask

  task automatic idle();
    ev_valid = 0;
    step();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    // R1: reset values before release
    check("R1 reset sr0", {24'd0, sr0}, 32'h0C);
    check("R1 reset sr1", {24'd0, sr1}, 32'h00);
    rst_n = 1;
    @(negedge clk);
    idle();
    // R3: unarmed status write ignored
    ev(3'd4, 2'd1, 8'h00, 8'h00);
    check("R3 unarmed level", {30'd0, sr0[3:2]}, 32'd3);
    // R3: intervening other command cancels arming
    ev(3'd1, 0, 0, 0); ev(3'd0, 0, 0, 0); ev(3'd4, 2'd1, 8'h00, 8'h00);
    check("R3 broken arm", {30'd0, sr0[3:2]}, 32'd3);
    // R3: arm, idle cycles, write
    ev(3'd3, 0, 0, 0); idle(); idle(); ev(3'd4, 2'd1, 8'h00, 8'h00);
    check("R3 armed write", {30'd0, sr0[3:2]}, 32'd0);
    // R6 / R9
    ev(3'd1, 0, 0, 0);
    check("R6 wren sets latch", {31'd0, sr0[1]}, 32'd1);
    check("R9 chip erase allowed", {31'd0, chip_erase_ok}, 32'd1);
    // R5: bad length not executed, latch still cleared
    ev(3'd4, 2'd3, 8'h8C, 8'h0C);
    check("R5 length3 ignored", {24'd0, sr0}, 32'h00);
    // R5: two-byte write
    ev(3'd3, 0, 0, 0); ev(3'd4, 2'd2, 8'h84, 8'h0C);
    check("R5 two-byte sr0", {24'd0, sr0}, 32'h84);
    check("R5 two-byte sr1", {24'd0, sr1}, 32'h0C);
    // R4: pin lock
    wp_n = 0;
    ev(3'd3, 0, 0, 0); ev(3'd4, 2'd2, 8'h00, 8'h00);
    check("R4 pin locked", {24'd0, sr0}, 32'h84);
    wp_n = 1;
    ev(3'd3, 0, 0, 0); ev(3'd4, 2'd2, 8'h00, 8'h04);
    check("R4 pin high unlocks", {24'd0, sr1}, 32'h04);
    // R8: top lock only, level 00
    chk_addr = 18'h3E000; chk_span = 2'd3; idle();
    check("R8 top 64K span", {31'd0, chk_protected}, 32'd1);
    chk_addr = 18'h3EFFF; chk_span = 2'd0; idle();
    check("R8 byte below top", {31'd0, chk_protected}, 32'd0);
    // R7: level 01 boundary
    ev(3'd3, 0, 0, 0); ev(3'd4, 2'd2, 8'h04, 8'h08);
    chk_addr = 18'h2FFFF; idle();
    check("R7 below quarter", {31'd0, chk_protected}, 32'd0);
    chk_addr = 18'h30000; idle();
    check("R7 quarter start", {31'd0, chk_protected}, 32'd1);
    chk_addr = 18'h01000; chk_span = 2'd2; idle();
    check("R8 bottom via 32K", {31'd0, chk_protected}, 32'd1);
    // R5/R2: busy blocks write, busy shows
    op_busy = 1;
    ev(3'd3, 0, 0, 0); ev(3'd4, 2'd1, 8'h00, 8'h00);
    check("R5 busy write ignored", {30'd0, sr0[3:2]}, 32'd1);
    check("R2 busy bit", {31'd0, sr0[0]}, 32'd1);
    op_busy = 0;
    // R6: collision, set wins over auto-increment fall
    aai_mode = 1; ev(3'd1, 0, 0, 0);
    check("R2 aai bit", {31'd0, sr0[6]}, 32'd1);
    aai_mode = 0; ev(3'd1, 0, 0, 0);
    check("R6 set wins collision", {31'd0, sr0[1]}, 32'd1);
    aai_mode = 1; idle(); aai_mode = 0; idle();
    check("R6 aai fall clears", {31'd0, sr0[1]}, 32'd0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      ev_valid = ($urandom % 10) < 7;
      ev_kind  = 3'($urandom % 7);
      ev_len   = 2'($urandom);
      ev_d0    = 8'($urandom);
      ev_d1    = 8'($urandom);
      wp_n     = ($urandom % 3) != 0;
      op_busy  = ($urandom % 8) == 0;
      if (($urandom % 6) == 0) aai_mode = ~aai_mode;
      chk_addr = 18'($urandom);
      chk_span = 2'($urandom);
      step();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule